// File: doc/BRIEF.md
# Flag-Setting Integer Execute Unit

This block is the integer execute stage of a small load/store processor. Each cycle it receives an operation code that has already been decoded. It also receives a first register operand, and its second operand is either a second register or a short unsigned immediate. From these it forms a 64-bit result with no clock in the path. The unit covers addition and subtraction, bitwise AND, OR and XOR, and logical shifts by a constant amount. It also has two 16-bit move-wide forms: one clears the rest of the destination, the other inserts a constant into the destination's previous value.

Four condition codes are held in a register: negative, zero, carry and overflow. They change only on the edge at which a valid flag-setting add or subtract is presented. Every other operation passes through without touching them, and so does a plain add or subtract. A branch stage can then test condition codes set by an earlier compare, even when other arithmetic runs in between.

Top module: `flagged_exec_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `flags` becomes 4'b0000. The flag bits are ordered {N, Z, C, V} from bit 3 down to bit 0.
- R2: Opcode 0 (add) gives `opnd_a` + operand2 modulo 2^64, and opcode 1 (subtract) gives `opnd_a` − operand2. Operand2 is `opnd_b` when `use_imm` is 0. When `use_imm` is 1, operand2 is `imm_val` zero-extended to 64 bits.
- R3: Opcodes 2 (add, set flags) and 3 (subtract, set flags) produce the same result as opcodes 0 and 1. When `op_valid` is high at the rising edge, they also load `flags`: N takes bit 63 of the result, and Z is 1 exactly when the result is zero.
- R4: For flag-setting operations, C is the carry out of bit 63, with subtraction computed as `opnd_a` + ~operand2 + 1. V is 1 when the signed 64-bit result overflows.
- R5: `flags` keeps its value at any edge where `op_valid` is low or the opcode is not 2 or 3. This includes plain add and subtract.
- R6: Opcodes 4, 5 and 6 give the bitwise AND, inclusive OR and exclusive OR of `opnd_a` and operand2.
- R7: Opcode 7 shifts `opnd_a` left by `shamt` (0..63) and opcode 8 shifts it right logically. Vacated bits are zero, and a `shamt` of 0 returns `opnd_a` unchanged.
- R8: Opcode 9 (move wide, zero) places `wide_const` at bit position 16×`wide_slot` and makes every other result bit zero.
- R9: Opcode 10 (move wide, keep) places `wide_const` at bit position 16×`wide_slot`, and all other result bits come from `prior_dst`.
- R10: Opcodes 11 to 15 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | The presented operation is real; gates the flag update |
| op_sel | input | 4 | Operation code |
| use_imm | input | 1 | Second operand comes from `imm_val` instead of `opnd_b` |
| opnd_a | input | 64 | First register operand |
| opnd_b | input | 64 | Second register operand |
| imm_val | input | 12 | Unsigned immediate |
| shamt | input | 6 | Constant shift amount |
| wide_const | input | 16 | Move-wide constant |
| wide_slot | input | 2 | Move-wide position (slot × 16 bits) |
| prior_dst | input | 64 | Previous destination value for move wide, keep |
| result | output | 64 | Combinational result |
| flags | output | 4 | Registered {N, Z, C, V} |

## Verification
The arithmetic operations are tried with several operand pairs. Adding one to the largest positive value must raise V and N without C. Adding one to all ones wraps to zero, which must raise Z and C. Subtracting a value from itself must set Z and C, and zero minus one must set N and clear C; taken together these pairs separate the borrow convention from the carry convention. Flag-setting operations are interleaved with plain arithmetic and with invalid flag-setting operations, to show that only a valid flag-setting operation moves the flags. The shift checks cover amounts 0 and 63, and the move-wide checks use a high slot and a middle slot over a non-zero previous destination, so that clearing and keeping give visibly different results.

// File: rtl/xu_pkg.sv
// Package: shared operation codes for the execute unit.
// Assumes the decoder supplies one of these 4-bit codes per cycle.
package xu_pkg;
    typedef enum logic [3:0] {
        XU_ADD  = 4'd0,
        XU_SUB  = 4'd1,
        XU_ADDF = 4'd2,
        XU_SUBF = 4'd3,
        XU_AND  = 4'd4,
        XU_OR   = 4'd5,
        XU_XOR  = 4'd6,
        XU_SHL  = 4'd7,
        XU_SHR  = 4'd8,
        XU_MVZ  = 4'd9,
        XU_MVK  = 4'd10
    } xu_op_e;

    localparam int unsigned FLAG_N = 3;
    localparam int unsigned FLAG_Z = 2;
    localparam int unsigned FLAG_C = 1;
    localparam int unsigned FLAG_V = 0;
endpackage

// File: rtl/xu_addsub.sv
// Adder/subtractor: one carry chain for both directions.
// Subtraction is done as a + ~b + 1, so the carry out means "no borrow".
// Assumes operands are W-bit two's-complement or unsigned values.
module xu_addsub #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    // Invert the second operand and inject the +1 for subtraction.
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        carry = wide[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/xu_bitlogic.sv
// Bitwise logic and constant logical shifts.
// Assumes shift amounts are below W; vacated bits fill with zeros.
module xu_bitlogic #(
    parameter int unsigned W    = 64,
    parameter int unsigned SH_W = 6
) (
    input  xu_pkg::xu_op_e  op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [SH_W-1:0] shamt,
    output logic [W-1:0]    y
);
    import xu_pkg::*;

    // Pick the logic or shift outcome for the current operation.
    always_comb begin
        unique case (op)
            XU_AND:  y = a & b;
            XU_OR:   y = a | b;
            XU_XOR:  y = a ^ b;
            XU_SHL:  y = a << shamt;
            XU_SHR:  y = a >> shamt;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/xu_movewide.sv
// Move-wide insertion of a K_W-bit constant into one of W/K_W lanes.
// Other lanes are cleared, or copied from the prior destination when keep=1.
// Assumes W is a multiple of K_W.
module xu_movewide #(
    parameter int unsigned W   = 64,
    parameter int unsigned K_W = 16,
    localparam int unsigned LANES  = W / K_W,
    localparam int unsigned SLOT_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [K_W-1:0]    kval,
    input  logic [SLOT_W-1:0] slot,
    input  logic [W-1:0]      prior,
    input  logic              keep,
    output logic [W-1:0]      y
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Each lane takes the constant, the old bits, or zero.
        always_comb begin
            if (slot == SLOT_W'(g))
                y[g*K_W +: K_W] = kval;
            else if (keep)
                y[g*K_W +: K_W] = prior[g*K_W +: K_W];
            else
                y[g*K_W +: K_W] = '0;
        end
    end
endmodule

// File: rtl/flagged_exec_unit.sv
// Top of the integer execute unit: combinational result plus a
// registered {N,Z,C,V} that only valid flag-setting add/sub update.
// Assumes op_sel comes pre-decoded; synchronous active-low reset.
module flagged_exec_unit #(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned IMM_W   = 12,
    parameter int unsigned CONST_W = 16,
    localparam int unsigned SH_W   = $clog2(DATA_W),
    localparam int unsigned SLOT_W = $clog2(DATA_W / CONST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [SH_W-1:0]   shamt,
    input  logic [CONST_W-1:0] wide_const,
    input  logic [SLOT_W-1:0] wide_slot,
    input  logic [DATA_W-1:0] prior_dst,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags
);
    import xu_pkg::*;

    xu_op_e            op;
    logic [DATA_W-1:0] operand2;
    logic [DATA_W-1:0] arith_y, logic_y, wide_y;
    logic              is_sub, carry, ovf, sets_flags;

    // Decode the operation and pick the second operand.
    always_comb begin
        op         = xu_op_e'(op_sel);
        operand2   = use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm_val} : opnd_b;
        is_sub     = (op == XU_SUB) || (op == XU_SUBF);
        sets_flags = (op == XU_ADDF) || (op == XU_SUBF);
    end

    xu_addsub #(.W(DATA_W)) u_arith (
        .a(opnd_a), .b(operand2), .sub(is_sub),
        .sum(arith_y), .carry(carry), .ovf(ovf)
    );

    xu_bitlogic #(.W(DATA_W), .SH_W(SH_W)) u_logic (
        .op(op), .a(opnd_a), .b(operand2), .shamt(shamt), .y(logic_y)
    );

    xu_movewide #(.W(DATA_W), .K_W(CONST_W)) u_wide (
        .kval(wide_const), .slot(wide_slot), .prior(prior_dst),
        .keep(op == XU_MVK), .y(wide_y)
    );

    // Route the selected unit to the result.
    always_comb begin
        unique case (op)
            XU_ADD, XU_SUB, XU_ADDF, XU_SUBF:       result = arith_y;
            XU_AND, XU_OR, XU_XOR, XU_SHL, XU_SHR:  result = logic_y;
            XU_MVZ, XU_MVK:                         result = wide_y;
            default:                                result = '0;
        endcase
    end

    // Condition-code register: load only on a valid flag-setting op.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= 4'b0000;
        else if (op_valid && sets_flags) begin
            flags[FLAG_N] <= arith_y[DATA_W-1];
            flags[FLAG_Z] <= (arith_y == '0);
            flags[FLAG_C] <= carry;
            flags[FLAG_V] <= ovf;
        end
    end
endmodule

// File: rtl/xu_checker.sv
// Checker for flagged_exec_unit: port-level properties over time.
// Assumes the opcode encoding from xu_pkg; bound into every instance.
module xu_checker #(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned CONST_W = 16,
    parameter int unsigned SH_W    = 6,
    parameter int unsigned SLOT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [SH_W-1:0]   shamt,
    input logic [SLOT_W-1:0] wide_slot,
    input logic [DATA_W-1:0] prior_dst,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        flags
);
    logic [DATA_W-1:0] lane_mask;
    logic              fset;

    // Mask of the lane a move-wide writes; flag-setting decode.
    always_comb begin
        lane_mask = {{(DATA_W-CONST_W){1'b0}}, {CONST_W{1'b1}}} << (int'(wide_slot) * CONST_W);
        fset      = op_valid && (op_sel == 4'd2 || op_sel == 4'd3);
    end

    a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fset |=> $stable(flags));

    a_r3_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fset |=> flags[3] == $past(result[DATA_W-1]));

    a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fset |=> flags[2] == ($past(result) == '0));

    a_r8_movz_clear: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 4'd9 |-> (result & ~lane_mask) == '0);

    a_r9_movk_keep: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 4'd10 |-> (result & ~lane_mask) == (prior_dst & ~lane_mask));

    a_r7_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd7 || op_sel == 4'd8) && shamt == '0 |-> result == opnd_a);

    a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel > 4'd10 |-> result == '0);
endmodule

bind flagged_exec_unit xu_checker #(
    .DATA_W(DATA_W), .CONST_W(CONST_W), .SH_W(SH_W), .SLOT_W(SLOT_W)
) u_xu_checker (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .shamt(shamt), .wide_slot(wide_slot),
    .prior_dst(prior_dst), .result(result), .flags(flags)
);

// File: tb/tb_flagged_exec_unit.sv
module tb_flagged_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_sel;
    logic        use_imm;
    logic [63:0] opnd_a, opnd_b, prior_dst;
    logic [11:0] imm_val;
    logic [5:0]  shamt;
    logic [15:0] wide_const;
    logic [1:0]  wide_slot;
    logic [63:0] result;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    flagged_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .use_imm(use_imm), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_val(imm_val),
        .shamt(shamt), .wide_const(wide_const), .wide_slot(wide_slot),
        .prior_dst(prior_dst), .result(result), .flags(flags)
    );

    task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s result act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk4(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s flags act=%b exp=%b", req, act, exp);
        end
    endtask

    // Present one operation at a falling edge, let the result settle.
    task automatic apply(logic v, logic [3:0] op, logic ui, logic [63:0] a, logic [63:0] b,
                         logic [11:0] im);
        @(negedge clk);
        op_valid = v; op_sel = op; use_imm = ui;
        opnd_a = a; opnd_b = b; imm_val = im;
        #1;
    endtask

    // Expected {N,Z,C,V} computed from R3/R4.
    function automatic logic [3:0] exp_flags(logic [63:0] a, logic [63:0] b, logic sub);
        logic [64:0] t;
        logic        v;
        t = sub ? ({1'b0, a} + {1'b0, ~b} + 65'd1) : ({1'b0, a} + {1'b0, b});
        v = sub ? ((a[63] != b[63]) && (t[63] != a[63]))
                : ((a[63] == b[63]) && (t[63] != a[63]));
        return {t[63], t[63:0] == 64'd0, t[64], v};
    endfunction

    task automatic test_reset();
        rst_n = 1'b0; op_valid = 1'b0; op_sel = 4'd0; use_imm = 1'b0;
        opnd_a = '0; opnd_b = '0; imm_val = '0; shamt = '0;
        wide_const = '0; wide_slot = '0; prior_dst = '0;
        repeat (3) @(posedge clk);
        #1 chk4("R1", flags, 4'b0000);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic test_plain_arith();
        apply(1, 4'd0, 0, 64'd1234, 64'd4321, '0);
        chk64("R2 add reg", result, 64'd5555);
        apply(1, 4'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd99, 12'hFFF);
        chk64("R2 add imm", result, 64'd4094);
        apply(1, 4'd1, 0, 64'd10, 64'd20, '0);
        chk64("R2 sub reg", result, 64'hFFFF_FFFF_FFFF_FFF6);
        apply(1, 4'd1, 1, 64'd500, 64'd1, 12'd20);
        chk64("R2 sub imm", result, 64'd480);
    endtask

    task automatic flag_case(string req, logic [3:0] op, logic ui, logic [63:0] a,
                             logic [63:0] b, logic [11:0] im);
        logic [63:0] b2;
        logic [63:0] r;
        b2 = ui ? {52'd0, im} : b;
        r  = (op == 4'd3) ? a - b2 : a + b2;
        apply(1, op, ui, a, b, im);
        chk64(req, result, r);
        @(posedge clk); #1;
        chk4(req, flags, exp_flags(a, b2, op == 4'd3));
    endtask

    task automatic test_flag_ops();
        flag_case("R4 adds V", 4'd2, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, '0);
        chk4("R4 adds V lit", flags, 4'b1001);
        flag_case("R4 adds C", 4'd2, 1, 64'hFFFF_FFFF_FFFF_FFFF, '0, 12'd1);
        chk4("R3 adds Z lit", flags, 4'b0110);
        flag_case("R4 subs eq", 4'd3, 0, 64'd77, 64'd77, '0);
        chk4("R4 subs eq lit", flags, 4'b0110);
        flag_case("R3 subs neg", 4'd3, 1, 64'd0, '0, 12'd1);
        chk4("R3 subs neg lit", flags, 4'b1000);
        flag_case("R4 subs ovf", 4'd3, 0, 64'h8000_0000_0000_0000, 64'd1, '0);
        chk4("R4 subs ovf lit", flags, 4'b0011);
    endtask

    task automatic test_flags_hold();
        logic [3:0] held;
        flag_case("R3 setup", 4'd3, 0, 64'd5, 64'd9, '0);
        held = flags;
        apply(1, 4'd0, 0, 64'd0, 64'd0, '0);
        @(posedge clk); #1 chk4("R5 plain add", flags, held);
        apply(1, 4'd1, 0, 64'd3, 64'd3, '0);
        @(posedge clk); #1 chk4("R5 plain sub", flags, held);
        apply(0, 4'd2, 0, 64'd0, 64'd0, '0);
        @(posedge clk); #1 chk4("R5 invalid adds", flags, held);
        apply(1, 4'd4, 0, 64'd0, 64'd0, '0);
        @(posedge clk); #1 chk4("R5 logic op", flags, held);
    endtask

    task automatic test_logic();
        apply(1, 4'd4, 0, 64'hF0F0_1234_5678_FFFF, 64'h0FF0_FFFF_0000_00F0, '0);
        chk64("R6 and", result, 64'h00F0_1234_0000_00F0);
        apply(1, 4'd5, 1, 64'h1000_0000_0000_0000, '1, 12'hA5A);
        chk64("R6 or imm", result, 64'h1000_0000_0000_0A5A);
        apply(1, 4'd6, 0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000, '0);
        chk64("R6 xor", result, 64'h5555_AAAA_5555_AAAA);
    endtask

    task automatic test_shift();
        shamt = 6'd0;
        apply(1, 4'd7, 0, 64'h8123_4567_89AB_CDEF, '0, '0);
        chk64("R7 shl 0", result, 64'h8123_4567_89AB_CDEF);
        shamt = 6'd4; #1;
        chk64("R7 shl 4", result, 64'h1234_5678_9ABC_DEF0);
        op_sel = 4'd8; #1;
        chk64("R7 shr 4", result, 64'h0812_3456_789A_BCDE);
        shamt = 6'd63; #1;
        chk64("R7 shr 63", result, 64'd1);
        op_sel = 4'd7; #1;
        chk64("R7 shl 63", result, 64'h8000_0000_0000_0000);
        shamt = 6'd0; op_sel = 4'd8; #1;
        chk64("R7 shr 0", result, 64'h8123_4567_89AB_CDEF);
    endtask

    task automatic test_movewide();
        prior_dst = 64'h1111_2222_3333_4444;
        wide_const = 16'hBEEF; wide_slot = 2'd3;
        apply(1, 4'd9, 0, '0, '0, '0);
        chk64("R8 movz slot3", result, 64'hBEEF_0000_0000_0000);
        wide_slot = 2'd1; #1;
        chk64("R8 movz slot1", result, 64'h0000_0000_BEEF_0000);
        op_sel = 4'd10; #1;
        chk64("R9 movk slot1", result, 64'h1111_2222_BEEF_4444);
        wide_slot = 2'd0; #1;
        chk64("R9 movk slot0", result, 64'h1111_2222_3333_BEEF);
    endtask

    task automatic test_unused();
        apply(1, 4'd11, 0, '1, '1, '0);
        chk64("R10 op11", result, 64'd0);
        apply(1, 4'd15, 0, '1, '1, '0);
        chk64("R10 op15", result, 64'd0);
    endtask

    initial begin
        test_reset();
        test_plain_arith();
        test_flag_ops();
        test_flags_hold();
        test_logic();
        test_shift();
        test_movewide();
        test_unused();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule